// File: doc/BRIEF.md
# Serial-Programmed Track Observation Selector

This test-mode block picks any subset of five comparator track signals and folds them onto one observation pin. The subset is held in a five-bit select mask. The mask is loaded one bit at a time from a serial data pin, clocked by an active-low shift clock. Every mask bit that is set lets its track into an exclusive-OR reduction. The result of that reduction drives the observation output.

A tester first clears the mask and then clocks in the wanted pattern. After that it watches the output while the comparators toggle. With one bit set, the output repeats one track. With several bits set, the output carries the parity of the enabled tracks.

The shift clock and the serial data arrive without timing guarantees. Both are therefore resynchronised to the block clock, and the falling edge of the shift clock is detected after the synchroniser.

Top module: `track_sel_top`

## Requirements
- R1: While reset is asserted, and after reset is released, the select mask is all zeros and `obsOut` is 0.
- R2: Each falling edge of the synchronised `shiftClkN` shifts the mask by one place while `testEn` is 1. The mask moves toward bit 4, `serData` enters bit 0, and the old bit 4 is discarded. The new mask takes effect SYNC_STAGES+1 clock cycles after the falling edge reaches the input.
- R3: `serData` is taken as a level. The value shifted in is the one held at the pin while the shift clock falls.
- R4: Mask bit i (i = 0..4) enables `trackIn[i]`. With a single bit i set and `testEn` at 1, `obsOut` equals `trackIn[i]`.
- R5: With several mask bits set and `testEn` at 1, `obsOut` is the XOR of `trackIn[i]` over every set bit i. The track inputs reach the output through logic only, with no register.
- R6: When the mask is all zeros, `obsOut` is 0 for every track pattern.
- R7: While `testEn` is 0, shift-clock edges leave the mask unchanged and `obsOut` is 0. The mask is kept for when `testEn` returns to 1.
- R8: A clock edge with `clearIn` at 1 sets the mask to zero. This takes priority over a shift in the same cycle.
- R9: A shift clock held low for any number of cycles causes exactly one shift. Another shift needs a rising edge and then a new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shiftClkN | input | 1 | Serial shift clock; its falling edge is the active edge |
| serData | input | 1 | Serial mask data, read as a level |
| clearIn | input | 1 | Synchronous clear of the select mask |
| testEn | input | 1 | Test-mode enable |
| trackIn | input | 5 | Comparator track signals; bit i is track i |
| obsOut | output | 1 | XOR of the enabled tracks |

## Verification
The assertions assume that `trackIn` is steady around the clock edges. They also assume that `shiftClkN` and `serData` change only at a pace slower than the synchroniser, so that the data reaching the edge detector belongs to the same falling edge. The stimulus holds each shift-clock level for four clock cycles and keeps `serData` constant across the whole low phase. It moves the track pattern only on the inactive clock edge. Every mask from 0 to 31 is loaded and then tested against all 32 track patterns.

// File: rtl/track_sel_pkg.sv
package track_sel_pkg;
  localparam int TRACKS = 5;

  typedef struct packed {
    logic shiftStb;
    logic shiftBit;
    logic clearStb;
  } selStb_t;
endpackage

// File: rtl/track_sel_ctrl.sv
module track_sel_ctrl
  import track_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    shiftClkN,
  input  logic    serData,
  input  logic    clearIn,
  input  logic    testEn,
  output selStb_t stb
);
  localparam int LAST = SYNC_STAGES - 1;

  // one extra stage on the clock pipe holds the previous level for edge detection
  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe  <= '1;
      dataPipe <= '0;
    end else begin
      clkPipe  <= {clkPipe[SYNC_STAGES-1:0], shiftClkN};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  logic fallSeen;
  assign fallSeen = clkPipe[SYNC_STAGES] & ~clkPipe[LAST];

  always_comb begin
    stb.shiftStb = fallSeen & testEn;
    stb.shiftBit = dataPipe[LAST];
    stb.clearStb = clearIn;
  end
endmodule

// File: rtl/track_sel_dp.sv
module track_sel_dp
  import track_sel_pkg::*;
#(
  parameter int WIDTH = TRACKS
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStb_t          stb,
  input  logic             testEn,
  input  logic [WIDTH-1:0] trackIn,
  output logic [WIDTH-1:0] selMask,
  output logic             obsOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      selMask <= '0;
    else if (stb.clearStb)
      selMask <= '0;
    else if (stb.shiftStb)
      selMask <= {selMask[WIDTH-2:0], stb.shiftBit};
  end

  logic [WIDTH:0] parityChain;
  assign parityChain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign parityChain[i+1] = parityChain[i] ^ (selMask[i] & trackIn[i]);
  end

  assign obsOut = testEn & parityChain[WIDTH];
endmodule

// File: rtl/track_sel_top.sv
module track_sel_top
  import track_sel_pkg::*;
#(
  parameter int WIDTH       = TRACKS,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftClkN,
  input  logic             serData,
  input  logic             clearIn,
  input  logic             testEn,
  input  logic [WIDTH-1:0] trackIn,
  output logic             obsOut
);
  selStb_t          stb;
  logic [WIDTH-1:0] selMask;

  track_sel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftClkN(shiftClkN),
    .serData  (serData),
    .clearIn  (clearIn),
    .testEn   (testEn),
    .stb      (stb)
  );

  track_sel_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .testEn (testEn),
    .trackIn(trackIn),
    .selMask(selMask),
    .obsOut (obsOut)
  );
endmodule

// File: rtl/track_sel_chk.sv
module track_sel_chk
  import track_sel_pkg::*;
#(
  parameter int WIDTH = TRACKS
) (
  input logic             clk,
  input logic             rstN,
  input logic             testEn,
  input logic [WIDTH-1:0] trackIn,
  input logic             obsOut,
  input selStb_t          stb,
  input logic [WIDTH-1:0] selMask
);
  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearStb |=> (selMask == '0));

  // R2
  shift_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftStb && !stb.clearStb) |=>
      (selMask == {$past(selMask[WIDTH-2:0]), $past(stb.shiftBit)}));

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shiftStb && !stb.clearStb) |=> $stable(selMask));

  // R7
  shift_needs_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftStb |-> testEn);

  // R6
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selMask == '0) |-> !obsOut);

  // R4
  single_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(selMask) == 1 && testEn) |-> (obsOut == |(selMask & trackIn)));
endmodule

bind track_sel_top track_sel_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .testEn (testEn),
  .trackIn(trackIn),
  .obsOut (obsOut),
  .stb    (stb),
  .selMask(selMask)
);

// File: tb/tb_track_sel_top.sv
module tb_track_sel_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shiftClkN = 1'b1;
  logic       serData = 1'b0;
  logic       clearIn = 1'b0;
  logic       testEn = 1'b0;
  logic [4:0] trackIn = '0;
  logic       obsOut;

  int checks = 0;
  int fails = 0;
  logic [4:0] model = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  track_sel_top dut (
    .clk(clk), .rstN(rstN), .shiftClkN(shiftClkN), .serData(serData),
    .clearIn(clearIn), .testEn(testEn), .trackIn(trackIn), .obsOut(obsOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: obsOut=%0b expected=%0b (mask %05b tracks %05b)",
               req, act, exp, model, trackIn);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b, input int lowCycles);
    @(negedge clk);
    serData = b;
    shiftClkN = 1'b0;
    waitCycles(lowCycles);
    shiftClkN = 1'b1;
    waitCycles(4);
    if (testEn) model = {model[3:0], b};
  endtask

  task automatic clearMask();
    @(negedge clk);
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    model = '0;
  endtask

  function automatic logic expObs(input logic [4:0] m, input logic [4:0] t, input logic en);
    logic p = 1'b0;
    for (int i = 0; i < 5; i++) if (m[i]) p ^= t[i];
    return en & p;
  endfunction

  task automatic sweepTracks(input string req);
    for (int t = 0; t < 32; t++) begin
      @(negedge clk);
      trackIn = t[4:0];
      #1;
      check(req, obsOut, expObs(model, trackIn, testEn));
    end
  endtask

  initial begin
    waitCycles(200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    trackIn = 5'b11111;
    waitCycles(3);
    testEn = 1'b1;
    #1;
    // R1: held in reset, all tracks high, mask empty
    check("R1", obsOut, 1'b0);
    rstN = 1'b1;
    waitCycles(2);
    check("R1", obsOut, 1'b0);

    // R2 R4 R5 R6: every mask against every track pattern
    for (int m = 0; m < 32; m++) begin
      clearMask();
      for (int b = 4; b >= 0; b--) shiftBit(m[b], 4);
      if (m == 0) sweepTracks("R6");
      else if ($countones(m) == 1) sweepTracks("R4");
      else sweepTracks("R5");
    end

    // R2: a sixth bit pushes the old bit 4 out
    clearMask();
    shiftBit(1'b1, 4);
    for (int b = 0; b < 5; b++) shiftBit(1'b0, 4);
    sweepTracks("R2");

    // R3: data held through the low phase is what enters
    clearMask();
    shiftBit(1'b1, 6);
    sweepTracks("R3");

    // R9: long low phase gives one shift only
    clearMask();
    shiftBit(1'b1, 30);
    shiftBit(1'b0, 4);
    sweepTracks("R9");

    // R7: test mode off, shifts ignored and output quiet
    clearMask();
    for (int b = 4; b >= 0; b--) shiftBit(b[0], 4);
    testEn = 1'b0;
    for (int b = 0; b < 5; b++) shiftBit(1'b1, 4);
    sweepTracks("R7");
    testEn = 1'b1;
    sweepTracks("R7");

    // R8: clear wins over a shift edge in the same window
    @(negedge clk);
    serData = 1'b1;
    shiftClkN = 1'b0;
    clearIn = 1'b1;
    waitCycles(5);
    shiftClkN = 1'b1;
    waitCycles(4);
    clearIn = 1'b0;
    model = '0;
    sweepTracks("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule